// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is the request front end of a multi-bank scratchpad memory shared by a group of lanes. Each cycle the block can take one group request. In that request every lane has an activity bit and a word address, and for writes it also has a data word. The operation, read or write, is common to the whole request. The low address bits choose a bank and the upper bits choose a row inside that bank. Each bank can serve one row per cycle. When the active lanes reach several different rows of one bank, the block splits the request into passes and keeps the requester stalled until every lane is served.

In each pass, every bank takes the address of its lowest-numbered lane that is still pending. Every pending lane that presents that same address is served in that pass. A read is therefore shared by all lanes that ask for the same word. For a write, the data of the highest-numbered matching lane goes into the word. On a read request the per-lane results are collected into an output vector. When the last lane completes, a one-cycle completion pulse goes out together with a count of the passes that were used.

With the default configuration there are 32 lanes and 32 banks of 32 rows, each row one 32-bit word. The storage is a simple per-bank register array whose read is combinational.

Top module: `spad_bank_serializer`

## Requirements
- R1: The bank of a word address is its low log2(BANKS) bits (address modulo 32 by default) and the row is the remaining upper bits. A unit-stride request, where lane i uses base+i, finishes in one pass.
- R2: The pass count of a request is the largest number of distinct addresses that active lanes present to any single bank, with a minimum of one.
- R3: Active lanes that present the identical address use one bank access between them. On a read they all receive the same word.
- R4: A request where lane i uses address i*32+j places every lane in one bank and needs exactly 32 passes. The pass count never exceeds LANES.
- R5: Inactive lanes do not change the pass count. Their read result is zero when the completion pulse arrives.
- R6: `busy` is high from the cycle after a request is accepted, for exactly as many cycles as the pass count. A `req_valid` seen while `busy` is high is ignored and writes nothing.
- R7: `done` is high for exactly one cycle, in the cycle right after the last busy cycle. `rdata` is valid in that cycle and holds until the next request is accepted.
- R8: When several active lanes of one write request share an address, the word afterwards holds the data of the highest-numbered of those lanes.
- R9: A read returns, for each active lane, the last value written to that lane's address.
- R10: After reset `busy`, `done` and `pass_count` are zero. `pass_count` is cleared on accept, rises by one in each busy cycle, and holds while idle.
- R11: A request with no active lanes takes exactly one pass and returns all-zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe; it is taken only while `busy` is low |
| req_write | input | 1 | 1 = every active lane writes, 0 = every active lane reads |
| req_act | input | LANES | Per-lane activity bits |
| req_addr | input | LANES*ADDR_W | Per-lane word addresses; lane l is at bits [l*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Per-lane write data; lane l is at bits [l*DATA_W +: DATA_W] |
| busy | output | 1 | Request in progress; the requester is stalled |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | LANES*DATA_W | Per-lane read results, in the same lane layout as the write data |
| pass_count | output | $clog2(LANES+1) | Number of passes (cycles) used by the latest request |

## Verification
A request that is accepted at clock edge E0 with an expected pass count of k raises `busy` after E0 and drops it after edge Ek. `done`, the final `pass_count` and `rdata` are due in the cycle after Ek, and `done` must be low again one cycle later. The bench drives and samples on falling edges. It counts busy cycles until it sees `done`, then checks in that cycle the pass count, the busy-cycle count and every lane's read word against values it computes itself, and checks `done` low on the next falling edge. The expected pass count comes from counting the distinct active addresses per bank in the bench. Read data comes from a bench memory model that applies writes in lane order, so the highest lane wins.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_SERVE = 1'b1
  } phase_e;
endpackage

// File: rtl/spad_rst_sync.sv
module spad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/spad_bank_select.sv
// Per-bank selection for one pass: the lowest pending lane of each bank
// picks the address, every pending lane with that address is granted, and
// the highest granted lane supplies the write data.
module spad_bank_select #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0][DATA_W-1:0] wdata,
  output logic [BANKS-1:0]             hit,
  output logic [BANKS-1:0][ADDR_W-1:0] sel_addr,
  output logic [BANKS-1:0][DATA_W-1:0] sel_wdata,
  output logic [LANES-1:0]             grant
);
  localparam int BANK_BITS = $clog2(BANKS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              hit_b;
    logic [ADDR_W-1:0] addr_b;
    logic [DATA_W-1:0] wd_b;

    always_comb begin
      hit_b  = 1'b0;
      addr_b = '0;
      // scan downwards so the lowest pending lane is the last to assign
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && (addr[l][BANK_BITS-1:0] == BANK_BITS'(b))) begin
          hit_b  = 1'b1;
          addr_b = addr[l];
        end
      end
      // scan upwards so the highest matching lane supplies the data
      wd_b = '0;
      for (int l = 0; l < LANES; l++) begin
        if (hit_b && pend[l] && (addr[l] == addr_b)) begin
          wd_b = wdata[l];
        end
      end
    end

    assign hit[b]       = hit_b;
    assign sel_addr[b]  = addr_b;
    assign sel_wdata[b] = wd_b;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      grant[l] = pend[l] && (addr[l] == sel_addr[addr[l][BANK_BITS-1:0]]);
    end
  end
endmodule

// File: rtl/spad_bank_ram.sv
module spad_bank_ram #(
  parameter int BANKS  = 32,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic [BANKS-1:0]             we,
  input  logic [BANKS-1:0][ROW_W-1:0]  row,
  input  logic [BANKS-1:0][DATA_W-1:0] wdata,
  output logic [BANKS-1:0][DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
      if (we[b]) begin
        mem_q[row[b]] <= wdata[b];
      end
    end

    assign rdata[b] = mem_q[row[b]];
  end
endmodule

// File: rtl/spad_bank_serializer.sv
module spad_bank_serializer #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_act,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES*DATA_W-1:0] req_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]        pass_count
);
  import spad_pkg::*;

  localparam int BANK_BITS = $clog2(BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS;

  logic rst_sync_n;

  spad_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // control state
  phase_e                      phase_q, phase_n;
  logic [LANES-1:0]            pend_q, pend_n;
  logic                        wr_q, wr_n;
  logic                        done_q, done_n;
  logic [CNT_W-1:0]            pass_q, pass_n;
  logic [LANES-1:0][DATA_W-1:0] rd_q, rd_n;
  // captured request payload (no reset, loaded under enable)
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;

  logic load_en;
  logic serve;
  logic rd_en;

  assign serve   = (phase_q == PH_SERVE);
  assign load_en = (phase_q == PH_IDLE) && req_valid;
  assign rd_en   = load_en || serve;

  // bank selection and storage
  logic [BANKS-1:0]             bank_hit;
  logic [BANKS-1:0][ADDR_W-1:0] bank_addr;
  logic [BANKS-1:0][DATA_W-1:0] bank_wd;
  logic [BANKS-1:0][DATA_W-1:0] bank_rd;
  logic [BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [BANKS-1:0]             bank_we;
  logic [LANES-1:0]             grant;
  logic [LANES-1:0][DATA_W-1:0] lane_rd;

  spad_bank_select #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_sel (
    .pend     (pend_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .hit      (bank_hit),
    .sel_addr (bank_addr),
    .sel_wdata(bank_wd),
    .grant    (grant)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_port
    assign bank_row[b] = bank_addr[b][ADDR_W-1:BANK_BITS];
    assign bank_we[b]  = serve && wr_q && bank_hit[b];
  end

  spad_bank_ram #(
    .BANKS (BANKS),
    .ROW_W (ROW_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (bank_we),
    .row  (bank_row),
    .wdata(bank_wd),
    .rdata(bank_rd)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_rd[l] = bank_rd[addr_q[l][BANK_BITS-1:0]];
    end
  end

  // next state
  always_comb begin
    phase_n = phase_q;
    pend_n  = pend_q;
    wr_n    = wr_q;
    done_n  = 1'b0;
    pass_n  = pass_q;
    rd_n    = rd_q;
    if (phase_q == PH_IDLE) begin
      if (req_valid) begin
        phase_n = PH_SERVE;
        pend_n  = req_act;
        wr_n    = req_write;
        pass_n  = '0;
        rd_n    = '0;
      end
    end else begin
      pass_n = pass_q + CNT_W'(1);
      pend_n = pend_q & ~grant;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l] && !wr_q) begin
          rd_n[l] = lane_rd[l];
        end
      end
      if ((pend_q & ~grant) == '0) begin
        phase_n = PH_IDLE;
        done_n  = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= '0;
    end else begin
      phase_q <= phase_n;
      pend_q  <= pend_n;
      wr_q    <= wr_n;
      done_q  <= done_n;
      pass_q  <= pass_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign busy       = serve;
  assign done       = done_q;
  assign rdata      = rd_q;
  assign pass_count = pass_q;
endmodule

// File: rtl/spad_bank_serializer_chk.sv
module spad_bank_serializer_chk #(
  parameter int LANES = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] pass_count
);
  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy falling is followed by completion in that same cycle
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6: never busy and done together
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: an idle request strobe is accepted on the next cycle
  a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && pass_count == '0));

  // R10: one pass per busy cycle
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pass_count == $past(pass_count) + CNT_W'(1)));

  // R10: count holds while idle and no request
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(pass_count));

  // R4: never more passes than lanes
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pass_count <= CNT_W'(LANES));
endmodule

bind spad_bank_serializer spad_bank_serializer_chk #(
  .LANES(LANES),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .pass_count(pass_count)
);

// File: tb/sim_spad_bank_serializer.sv
module sim_spad_bank_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                    rst_n;
  logic                    req_valid;
  logic                    req_write;
  logic [LANES-1:0]        req_act;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES*DATA_W-1:0] req_wdata;
  logic                    busy;
  logic                    done;
  logic [LANES*DATA_W-1:0] rdata;
  logic [CNT_W-1:0]        pass_count;

  spad_bank_serializer #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_act(req_act), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .pass_count(pass_count)
  );

  int checks = 0;
  int errors = 0;

  logic [ADDR_W-1:0] la [LANES];
  logic [DATA_W-1:0] lw [LANES];
  logic [LANES-1:0]  lact;
  logic [DATA_W-1:0] mdl [WORDS];

  function automatic logic [DATA_W-1:0] pat(int a, int g);
    return (32'(a) * 32'h9E37_79B9) ^ {g[15:0], a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int exp_passes();
    int cnt [BANKS];
    int mx;
    bit dup;
    for (int b = 0; b < BANKS; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      if (lact[l]) begin
        dup = 1'b0;
        for (int m = 0; m < l; m++)
          if (lact[m] && la[m] == la[l]) dup = 1'b1;
        if (!dup) cnt[int'(la[l]) % BANKS]++;
      end
    end
    mx = 0;
    for (int b = 0; b < BANKS; b++) if (cnt[b] > mx) mx = cnt[b];
    if (mx == 0) mx = 1;
    return mx;
  endfunction

  task automatic drive_lanes();
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*ADDR_W +: ADDR_W]  = la[l];
      req_wdata[l*DATA_W +: DATA_W] = lw[l];
    end
    req_act = lact;
  endtask

  task automatic run(input bit wr, input bit inject, input string tag);
    int exp;
    int cyc;
    int guard;
    int bad_lane;
    logic [DATA_W-1:0] got_w;
    logic [DATA_W-1:0] exp_w;
    exp = exp_passes();
    @(negedge clk);
    req_write = wr;
    drive_lanes();
    req_valid = 1'b1;
    @(negedge clk);
    cyc = 0;
    guard = 0;
    while (1) begin
      req_valid = 1'b0;
      if (done || guard >= 200) break;
      if (busy) cyc++;
      if (inject && busy && cyc == 1) begin
        // stray request while stalled: must be ignored (R6)
        for (int l = 0; l < LANES; l++) begin
          req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(l);
          req_wdata[l*DATA_W +: DATA_W] = 32'hBAD0_0000 | 32'(l);
        end
        req_act   = '1;
        req_write = 1'b1;
        req_valid = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, tag, "R7 done pulse seen", longint'(done), 1);
    chk(int'(pass_count) == exp, tag, "R2 pass count", longint'(pass_count), exp);
    chk(cyc == exp, tag, "R6 busy cycles", cyc, exp);
    if (!wr) begin
      bad_lane = -1;
      got_w = '0;
      exp_w = '0;
      for (int l = 0; l < LANES; l++) begin
        logic [DATA_W-1:0] e;
        e = lact[l] ? mdl[la[l]] : '0;
        if (bad_lane < 0 && rdata[l*DATA_W +: DATA_W] !== e) begin
          bad_lane = l;
          got_w = rdata[l*DATA_W +: DATA_W];
          exp_w = e;
        end
      end
      chk(bad_lane < 0, tag, "R9/R5 lane read data", longint'(got_w), longint'(exp_w));
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lact[l]) mdl[la[l]] = lw[l];
    end
    got_w = rdata[DATA_W-1:0];
    @(negedge clk);
    chk(done == 1'b0, tag, "R7 done drops after one cycle", longint'(done), 0);
    chk(rdata[DATA_W-1:0] == got_w, tag, "R7 rdata holds", longint'(rdata[DATA_W-1:0]), longint'(got_w));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_act = '0;
    req_addr = '0;
    req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10", "reset busy", longint'(busy), 0);
    chk(done == 1'b0, "R10", "reset done", longint'(done), 0);
    chk(pass_count == '0, "R10", "reset pass count", longint'(pass_count), 0);

    // R1: fill the whole memory with unit-stride writes
    for (int k = 0; k < WORDS / LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin
        la[l] = ADDR_W'(k * LANES + l);
        lw[l] = pat(k * LANES + l, 1);
      end
      lact = '1;
      run(1'b1, 1'b0, "R1");
    end

    // R1: unit-stride reads at aligned and unaligned bases
    foreach (la[i]) lw[i] = '0;
    for (int bi = 0; bi < 4; bi++) begin
      int base;
      base = (bi == 0) ? 0 : (bi == 1) ? 7 : (bi == 2) ? 500 : 991;
      for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(base + l);
      lact = '1;
      run(1'b0, 1'b0, "R1");
    end

    // R4: stride-32 worst case, one run with a stray request while busy
    for (int ji = 0; ji < 3; ji++) begin
      int j;
      j = (ji == 0) ? 0 : (ji == 1) ? 13 : 31;
      for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(l * 32 + j);
      lact = '1;
      run(1'b0, ji == 1, "R4");
    end
    // R6: words the stray request targeted are unchanged
    for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(l);
    lact = '1;
    run(1'b0, 1'b0, "R6");

    // R2: k distinct rows in one bank, lanes repeating addresses
    for (int k = 1; k <= LANES; k++) begin
      for (int l = 0; l < LANES; l++) la[l] = ADDR_W'((l % k) * 32 + (k % 32));
      lact = '1;
      run(1'b0, 1'b0, "R2");
    end

    // R2: other strides
    for (int si = 0; si < 5; si++) begin
      int s;
      s = (si == 0) ? 2 : (si == 1) ? 3 : (si == 2) ? 4 : (si == 3) ? 8 : 16;
      for (int l = 0; l < LANES; l++) la[l] = ADDR_W'((s * l + 5) % WORDS);
      lact = '1;
      run(1'b0, 1'b0, "R2");
    end

    // R3: full broadcast and two-address broadcast in one bank
    for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(555);
    lact = '1;
    run(1'b0, 1'b0, "R3");
    for (int l = 0; l < LANES; l++) la[l] = ADDR_W'((l < 16) ? 555 : 587);
    run(1'b0, 1'b0, "R3");

    // R5 / R11: growing activity masks on the stride-32 pattern
    for (int n = 0; n <= LANES; n++) begin
      for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(l * 32 + 9);
      lact = LANES'((64'd1 << n) - 64'd1);
      run(1'b0, 1'b0, (n == 0) ? "R11" : "R5");
    end
    lact = 32'hA5A5_0F0F;
    run(1'b0, 1'b0, "R5");

    // R8: same-address write conflicts
    for (int l = 0; l < LANES; l++) begin
      la[l] = ADDR_W'(300);
      lw[l] = pat(l, 7);
    end
    lact = 32'h00F0_0F01;
    run(1'b1, 1'b0, "R8");
    lact = '1;
    run(1'b0, 1'b0, "R8");
    for (int l = 0; l < LANES; l++) begin
      la[l] = ADDR_W'((l < 16) ? 64 : 65);
      lw[l] = pat(l, 9);
    end
    run(1'b1, 1'b0, "R8");
    run(1'b0, 1'b0, "R8");

    // R9: serialized writes then read back
    for (int l = 0; l < LANES; l++) begin
      la[l] = ADDR_W'(l * 32 + 20);
      lw[l] = pat(l, 11);
    end
    run(1'b1, 1'b0, "R9");
    for (int l = 0; l < LANES; l++) la[l] = ADDR_W'(31 * 32 + 20 - l * 32);
    run(1'b0, 1'b0, "R9");

    summary();
    $finish;
  end
endmodule